// File: doc/BRIEF.md
# Brown-out and Overvoltage Supervisor

This block supervises the single fault input of a switching power controller. Two comparators look at a scaled image of the bulk rail. One reports that the image is above the brown-out level (0.8 V). The other reports that it is above the overvoltage level (2.5 V). Neither comparator output is acted on directly. Each must keep a new value for a programmable confirmation window, nominally 30 µs, before the supervisor accepts it. A comparator that flips back inside the window restarts the count and leaves no trace.

From these qualified levels a three-state controller decides what the controller may do:
- **Brown-out:** switching is held off.
- **Run:** switching is allowed.
- **Overvoltage latch:** switching is held off until the supply falls below its reset level or a brown-out is confirmed.

Each exit from brown-out raises a one-cycle restart request. The surrounding logic uses that request to begin a full startup sequence with a fresh soft-start. A separate output turns on the hysteresis current source whenever the input is confirmed above the brown-out level.

The comparator and supply-reset inputs are expected to be synchronous to `clk` already. All outputs come straight from flip-flops.

Top module: `bosup_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sw_en_o`, `hyst_en_o` and `restart_o` are all 0.
- R2: `sw_en_o` is set once `bo_above_i` has been 1 for DELAY_CYC consecutive clock edges, provided the block is not latched. The output rises on the edge after the DELAY_CYC-th edge, and not before.
- R3: `restart_o` is high for exactly one cycle, in the same cycle that `sw_en_o` rises out of the brown-out state.
- R4: `hyst_en_o` is 1 exactly when the brown-out input is confirmed high, one edge after confirmation. `sw_en_o` is never 1 while `hyst_en_o` is 0.
- R5: Once `bo_above_i` has been 0 for DELAY_CYC consecutive edges, `sw_en_o` falls on the next edge.
- R6: A change of `bo_above_i` or `ov_above_i` that lasts fewer than DELAY_CYC edges changes no output.
- R7: A confirmed rising overvoltage event while running clears `sw_en_o` one edge after confirmation. `sw_en_o` then stays 0 even after `ov_above_i` returns to 0.
- R8: A confirmed brown-out clears the overvoltage latch. The next confirmed recovery sets `sw_en_o` and pulses `restart_o`.
- R9: `supply_rst_i` high at an edge forces the brown-out state, so `sw_en_o` is 0 in the following cycle. The latch is cleared, and if the brown-out input is still confirmed high, switching restarts with a restart pulse one edge later.
- R10: When brown-out and overvoltage are confirmed together, brown-out wins. An overvoltage level that is already confirmed when switching resumes does not latch. Only a new confirmed rising overvoltage event sets the latch again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bo_above_i | input | 1 | Comparator: input image above the brown-out level |
| ov_above_i | input | 1 | Comparator: input image above the overvoltage level |
| supply_rst_i | input | 1 | Supply has dropped below its logic reset level |
| sw_en_o | output | 1 | Switching allowed |
| hyst_en_o | output | 1 | Enable for the brown-out hysteresis current |
| restart_o | output | 1 | One-cycle request for a full restart with soft-start |

## Verification
The hardest situation to reach is the one R10 covers. It needs a confirmed overvoltage level that is already high when the supervisor leaves brown-out, so that a still-high level has to be told apart from a fresh rising event. Directed steps build this case: both inputs change together, the brown-out input recovers while overvoltage stays asserted, the output must stay enabled, and then overvoltage is dropped and re-confirmed. Random toggling with dwell times on both sides of the confirmation window then covers the glitch and priority mixes against a cycle model.

// File: rtl/bosup_pkg.sv
package bosup_pkg;
  typedef enum logic [1:0] {
    ST_BROWN = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } sup_state_t;
endpackage

// File: rtl/bosup_deglitch.sv
// Accepts a new input level only after it persisted DELAY_CYC edges.
module bosup_deglitch #(
  parameter int  DELAY_CYC = 1500,
  parameter logic INIT     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic qual_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      qual_o <= INIT;
    end else if (raw_i != qual_o) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        qual_o <= raw_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/bosup_ctrl.sv
module bosup_ctrl
  import bosup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bo_ok_i,
  input  logic ov_hit_i,
  input  logic supply_rst_i,
  output logic sw_en_o,
  output logic hyst_en_o,
  output logic restart_o
);
  sup_state_t st, nst;
  logic ov_prev;
  logic ov_rise;

  assign ov_rise = ov_hit_i & ~ov_prev;

  always_comb begin
    nst = st;
    unique case (st)
      ST_BROWN: if (bo_ok_i) nst = ST_RUN;
      ST_RUN: begin
        if (!bo_ok_i)     nst = ST_BROWN;
        else if (ov_rise) nst = ST_LATCH;
      end
      ST_LATCH: if (!bo_ok_i) nst = ST_BROWN;
      default: nst = ST_BROWN;
    endcase
    if (supply_rst_i) nst = ST_BROWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_BROWN;
      ov_prev   <= 1'b0;
      sw_en_o   <= 1'b0;
      hyst_en_o <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      st        <= nst;
      ov_prev   <= ov_hit_i;
      sw_en_o   <= (nst == ST_RUN);
      hyst_en_o <= bo_ok_i;
      restart_o <= (st == ST_BROWN) && (nst == ST_RUN);
    end
  end
endmodule

// File: rtl/bosup_top.sv
module bosup_top #(
  parameter int DELAY_CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic bo_above_i,
  input  logic ov_above_i,
  input  logic supply_rst_i,
  output logic sw_en_o,
  output logic hyst_en_o,
  output logic restart_o
);
  logic bo_ok, ov_hit;

  bosup_deglitch #(.DELAY_CYC(DELAY_CYC), .INIT(1'b0)) u_bo_dg (
    .clk(clk), .rst(rst), .raw_i(bo_above_i), .qual_o(bo_ok)
  );

  bosup_deglitch #(.DELAY_CYC(DELAY_CYC), .INIT(1'b0)) u_ov_dg (
    .clk(clk), .rst(rst), .raw_i(ov_above_i), .qual_o(ov_hit)
  );

  bosup_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bo_ok_i(bo_ok), .ov_hit_i(ov_hit),
    .supply_rst_i(supply_rst_i), .sw_en_o(sw_en_o),
    .hyst_en_o(hyst_en_o), .restart_o(restart_o)
  );
endmodule

// File: rtl/bosup_checker.sv
module bosup_checker #(
  parameter int DELAY_CYC = 1500
) (
  input logic clk,
  input logic rst,
  input logic bo_above_i,
  input logic supply_rst_i,
  input logic sw_en_o,
  input logic hyst_en_o,
  input logic restart_o
);
  localparam int LIM = DELAY_CYC + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) lo_cnt <= '0;
    else if (bo_above_i) lo_cnt <= '0;
    else if (lo_cnt != CW'(LIM)) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_SW_NEEDS_HYST: assert property (@(posedge clk) disable iff (rst)
    sw_en_o |-> hyst_en_o); // R4
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o); // R3
  AST_RESTART_WITH_SW: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> sw_en_o); // R3
  AST_SUPPLY_RST_OFF: assert property (@(posedge clk) disable iff (rst)
    supply_rst_i |=> !sw_en_o); // R9
  AST_LOW_STOPS: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt == CW'(LIM)) |-> !sw_en_o); // R5
endmodule

bind bosup_top bosup_checker #(.DELAY_CYC(DELAY_CYC)) u_bosup_checker (
  .clk(clk), .rst(rst), .bo_above_i(bo_above_i), .supply_rst_i(supply_rst_i),
  .sw_en_o(sw_en_o), .hyst_en_o(hyst_en_o), .restart_o(restart_o)
);

// File: tb/bosup_top_bench.sv
module bosup_top_bench;
  localparam int D = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bo = 1'b0, ov = 1'b0, sr = 1'b0;
  logic sw, hy, rs;
  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  bosup_top #(.DELAY_CYC(D)) u_bosup_top (
    .clk(clk), .rst(rst), .bo_above_i(bo), .ov_above_i(ov),
    .supply_rst_i(sr), .sw_en_o(sw), .hyst_en_o(hy), .restart_o(rs)
  );

  // Cycle model built from the requirements: 0 brown, 1 run, 2 latched
  int m_st, m_bc, m_oc;
  bit m_bq, m_oq, m_op, m_sw, m_hy, m_rs;

  function automatic int next_state(int s, bit bq, bit rise, bit srst);
    int n = s;
    if (s == 0 && bq) n = 1;
    else if (s == 1 && !bq) n = 0;
    else if (s == 1 && rise) n = 2;
    else if (s == 2 && !bq) n = 0;
    if (srst) n = 0;
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_bc = 0; m_oc = 0; m_bq = 0; m_oq = 0; m_op = 0;
      m_sw = 0; m_hy = 0; m_rs = 0;
    end else begin
      int n;
      n = next_state(m_st, m_bq, m_oq & ~m_op, sr);
      m_rs = (m_st == 0) && (n == 1);
      m_st = n;
      m_sw = (n == 1);
      m_hy = m_bq;
      m_op = m_oq;
      if (bo != m_bq) begin
        m_bc++; if (m_bc == D) begin m_bq = bo; m_bc = 0; end
      end else m_bc = 0;
      if (ov != m_oq) begin
        m_oc++; if (m_oc == D) begin m_oq = ov; m_oc = 0; end
      end else m_oc = 0;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk("R2/R5 model sw_en", sw, m_sw);
      chk("R4 model hyst_en", hy, m_hy);
      chk("R3 model restart", rs, m_rs);
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 sw in reset", sw, 1'b0);
    chk("R1 hyst in reset", hy, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1 sw after reset", sw, 1'b0);
    chk("R1 restart after reset", rs, 1'b0);
    // R6: short high pulse on brown-out input
    bo = 1; tick(D - 1); bo = 0; tick(30);
    chk("R6 bo glitch sw", sw, 1'b0);
    chk("R6 bo glitch hyst", hy, 1'b0);
    // R2/R3/R4: recovery timing
    bo = 1; tick(D);
    chk("R2 not early", sw, 1'b0);
    tick(1);
    chk("R2 sw on", sw, 1'b1);
    chk("R3 restart pulse", rs, 1'b1);
    chk("R4 hyst on", hy, 1'b1);
    tick(1);
    chk("R3 restart single", rs, 1'b0);
    // R6: short dip low
    bo = 0; tick(D - 1); bo = 1; tick(30);
    chk("R6 bo dip sw", sw, 1'b1);
    ov = 1; tick(D - 1); ov = 0; tick(30);
    chk("R6 ov glitch sw", sw, 1'b1);
    // R7: overvoltage latch
    ov = 1; tick(D);
    chk("R7 not early", sw, 1'b1);
    tick(1);
    chk("R7 latched off", sw, 1'b0);
    ov = 0; tick(40);
    chk("R7 stays latched", sw, 1'b0);
    chk("R7 no restart", rs, 1'b0);
    // R8: brown-out clears latch
    bo = 0; tick(D + 1);
    chk("R4 hyst off", hy, 1'b0);
    chk("R5 sw off", sw, 1'b0);
    bo = 1; tick(D + 1);
    chk("R8 sw on", sw, 1'b1);
    chk("R8 restart", rs, 1'b1);
    // R10: simultaneous events, brown-out wins
    ov = 1; bo = 0; tick(D + 1);
    chk("R10 brown wins", sw, 1'b0);
    bo = 1; tick(D + 1);
    chk("R10 recover", sw, 1'b1);
    chk("R10 restart", rs, 1'b1);
    tick(40);
    chk("R10 no relatch on held ov", sw, 1'b1);
    ov = 0; tick(D + 2);
    ov = 1; tick(D + 1);
    chk("R10 new ov latches", sw, 1'b0);
    // R9: supply reset clears the latch
    sr = 1; tick(1); sr = 0;
    chk("R9 off after supply reset", sw, 1'b0);
    tick(1);
    chk("R9 restart sw", sw, 1'b1);
    chk("R9 restart pulse", rs, 1'b1);
    tick(5);
    sr = 1; tick(1); sr = 0;
    chk("R9 supply reset stops run", sw, 1'b0);
    ov = 0; tick(3 * D);
    // Random phase against the cycle model
    model_on = 1'b1;
    void'($urandom(32'd1379));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) bo = ~bo;
      if ($urandom_range(0, 23) == 0) ov = ~ov;
      sr = ($urandom_range(0, 299) == 0);
      tick(1);
    end
    model_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule